// File: doc/BRIEF.md
# Strided Row Request Generator

This block turns one copy descriptor into a series of one-dimensional row requests for a downstream data mover. A descriptor names a 64-bit source base, a 64-bit destination base, a row length in bytes, a separate stride for each side, a row count and a configuration field. When the two-dimensional flag in that field is set, the block walks both address streams, each by its own stride, and emits one request per row. When the flag is clear, the descriptor passes through as a single request.

Descriptors enter on a valid/ready handshake and row requests leave on another. The block holds one descriptor at a time and refuses the next until the current one has issued its final row. One cycle after the final row is taken, it raises a single-cycle completion strobe carrying the 32-bit transfer tag of that descriptor. Software can use this strobe to retire transfers in order. Cutting rows into bus bursts and moving data happen further downstream.

Top module: `stride_row_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `desc_ready` is 1, `row_valid` is 0 and `done_pulse` is 0. An asynchronous reset taken in the middle of a transfer abandons it and returns the block to that state.
- R2: A descriptor is accepted on a clock edge where `desc_valid` and `desc_ready` are both 1. `desc_ready` is 0 from the cycle after acceptance until the cycle after the final row handshake, and is 1 again in that cycle. A `desc_valid` raised while busy, with any field values, changes none of the rows still to be issued and none of the reported tag.
- R3: If bit 1 of `desc_cfg` is 0 (one-dimensional mode), exactly one row is issued, with `row_src`=`desc_src`, `row_dst`=`desc_dst` and `row_len`=`desc_len`. The strides and the row count are ignored.
- R4: If bit 1 of `desc_cfg` is 1 (two-dimensional mode), exactly `desc_rows` rows are issued. Row k, counting from 0, carries `desc_src + k*desc_src_stride` and `desc_dst + k*desc_dst_stride`, where each stride is an unsigned value zero-extended to 64 bits. Every row carries `desc_len`.
- R5: In two-dimensional mode, a `desc_rows` of 0 is treated as 1, so exactly one row is issued at the base addresses.
- R6: Address arithmetic wraps modulo 2^64.
- R7: While `row_valid` is 1 and `row_ready` is 0, `row_valid`, `row_src`, `row_dst` and `row_len` hold their values into the next cycle.
- R8: `done_pulse` is 1 for exactly one cycle: the cycle after the handshake of the final row. In that cycle `done_id` equals the `desc_id` of the finished descriptor.
- R9: A `desc_len` of 0 still issues every row, each with `row_len`=0, followed by the completion strobe.
- R10: Bit 0 of `desc_cfg` has no effect on the number of rows, the addresses or the lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_src | input | 64 | Source base address |
| desc_dst | input | 64 | Destination base address |
| desc_len | input | 32 | Row length in bytes |
| desc_src_stride | input | 32 | Source step between rows |
| desc_dst_stride | input | 32 | Destination step between rows |
| desc_rows | input | 32 | Row count for two-dimensional mode |
| desc_cfg | input | 2 | Configuration; bit 1 selects two-dimensional mode |
| desc_id | input | 32 | Transfer tag reported on completion |
| row_valid | output | 1 | Row request present |
| row_ready | input | 1 | Downstream takes the row request |
| row_src | output | 64 | Row source address |
| row_dst | output | 64 | Row destination address |
| row_len | output | 32 | Row length in bytes |
| done_pulse | output | 1 | Single-cycle completion strobe |
| done_id | output | 32 | Tag of the completed descriptor |

## Verification
The hardest situation to reach from the ports is a fresh descriptor offered while rows are still pending, combined with back-pressure on the row side. This is where an early accept or a corrupted address stream would appear. The stimulus table drives several descriptors with `row_ready` held low on alternate rows. A directed case raises `desc_valid` with unrelated field values during a stalled row and then checks every remaining row and the reported tag against the original descriptor. Address wraparound is reached by placing the source base just below 2^64.

// File: rtl/rowgen_pkg.sv
package rowgen_pkg;
  localparam int unsigned CFG_2D_BIT = 1;

  typedef enum logic {
    RG_IDLE = 1'b0,
    RG_RUN  = 1'b1
  } rg_state_e;
endpackage

// File: rtl/rowgen_rst_sync.sv
module rowgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rowgen_addr.sv
module rowgen_addr #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned STRIDE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] stride,
  output logic [ADDR_W-1:0]   addr
);
  localparam int unsigned PAD_W = ADDR_W - STRIDE_W;

  logic [ADDR_W-1:0]   acc_q, acc_d;
  logic [STRIDE_W-1:0] stride_q, stride_d;
  logic                acc_en;

  always_comb begin
    acc_en   = load | step;
    acc_d    = acc_q;
    stride_d = stride_q;
    if (load) begin
      acc_d    = base;
      stride_d = stride;
    end else if (step) begin
      acc_d = acc_q + {{PAD_W{1'b0}}, stride_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      stride_q <= '0;
    end else if (acc_en) begin
      acc_q    <= acc_d;
      stride_q <= stride_d;
    end
  end

  assign addr = acc_q;

  // R6: one step advances by exactly the stride, modulo 2^ADDR_W
  a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr - $past(addr)) == {{PAD_W{1'b0}}, $past(stride_q)});
endmodule

// File: rtl/rowgen_ctrl.sv
module rowgen_ctrl
  import rowgen_pkg::*;
#(
  parameter int unsigned REP_W = 32,
  parameter int unsigned CFG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  input  logic [CFG_W-1:0] cfg,
  input  logic [REP_W-1:0] rows,
  input  logic             row_ready,
  output logic             desc_ready,
  output logic             accept,
  output logic             row_valid,
  output logic             step,
  output logic             last_hs
);
  rg_state_e        state_q, state_d;
  logic [REP_W-1:0] left_q, left_d;
  logic [REP_W-1:0] first_cnt;
  logic             is_2d;
  logic             row_hs;
  logic             on_last;
  logic             left_en;

  always_comb begin
    is_2d     = cfg[CFG_2D_BIT];
    first_cnt = {{(REP_W-1){1'b0}}, 1'b1};
    if (is_2d && (rows != '0)) first_cnt = rows;
  end

  always_comb begin
    desc_ready = (state_q == RG_IDLE);
    row_valid  = (state_q == RG_RUN);
    accept     = desc_ready & desc_valid;
    row_hs     = row_valid & row_ready;
    on_last    = (left_q == {{(REP_W-1){1'b0}}, 1'b1});
    last_hs    = row_hs & on_last;
    step       = row_hs & ~on_last;
  end

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    left_en = 1'b0;
    unique case (state_q)
      RG_IDLE: begin
        if (accept) begin
          state_d = RG_RUN;
          left_d  = first_cnt;
          left_en = 1'b1;
        end
      end
      RG_RUN: begin
        if (row_hs) begin
          left_d  = left_q - 1'b1;
          left_en = 1'b1;
          if (on_last) state_d = RG_IDLE;
        end
      end
      default: state_d = RG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RG_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  // R2: the block never offers a row while it is open for a new descriptor
  a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_ready && row_valid));

  // R2: a descriptor arriving while busy is not taken
  a_r2_no_busy_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && desc_valid && !last_hs) |=> row_valid && !desc_ready);

  // R3: one-dimensional mode produces a single row
  a_r3_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg[CFG_2D_BIT]) |=> (row_valid && on_last));

  // R5: zero row count in two-dimensional mode gives one row
  a_r5_zero_rows: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg[CFG_2D_BIT] && rows == '0) |=> (row_valid && on_last));
endmodule

// File: rtl/stride_row_expander.sv
module stride_row_expander #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned LEN_W    = 32,
  parameter int unsigned STRIDE_W = 32,
  parameter int unsigned REP_W    = 32,
  parameter int unsigned CFG_W    = 2,
  parameter int unsigned ID_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_valid,
  output logic                desc_ready,
  input  logic [ADDR_W-1:0]   desc_src,
  input  logic [ADDR_W-1:0]   desc_dst,
  input  logic [LEN_W-1:0]    desc_len,
  input  logic [STRIDE_W-1:0] desc_src_stride,
  input  logic [STRIDE_W-1:0] desc_dst_stride,
  input  logic [REP_W-1:0]    desc_rows,
  input  logic [CFG_W-1:0]    desc_cfg,
  input  logic [ID_W-1:0]     desc_id,
  output logic                row_valid,
  input  logic                row_ready,
  output logic [ADDR_W-1:0]   row_src,
  output logic [ADDR_W-1:0]   row_dst,
  output logic [LEN_W-1:0]    row_len,
  output logic                done_pulse,
  output logic [ID_W-1:0]     done_id
);
  localparam int unsigned N_CHAN = 2;

  logic rst_sync_n;
  logic accept, step, last_hs;

  logic [N_CHAN-1:0][ADDR_W-1:0]   chan_base;
  logic [N_CHAN-1:0][STRIDE_W-1:0] chan_stride;
  logic [N_CHAN-1:0][ADDR_W-1:0]   chan_addr;

  logic [LEN_W-1:0] len_q, len_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             done_q, done_d;

  rowgen_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rowgen_ctrl #(.REP_W(REP_W), .CFG_W(CFG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .desc_valid (desc_valid),
    .cfg        (desc_cfg),
    .rows       (desc_rows),
    .row_ready  (row_ready),
    .desc_ready (desc_ready),
    .accept     (accept),
    .row_valid  (row_valid),
    .step       (step),
    .last_hs    (last_hs)
  );

  assign chan_base[0]   = desc_src;
  assign chan_base[1]   = desc_dst;
  assign chan_stride[0] = desc_src_stride;
  assign chan_stride[1] = desc_dst_stride;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    rowgen_addr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .load   (accept),
      .step   (step),
      .base   (chan_base[g]),
      .stride (chan_stride[g]),
      .addr   (chan_addr[g])
    );
  end

  always_comb begin
    len_d  = accept ? desc_len : len_q;
    id_d   = accept ? desc_id  : id_q;
    done_d = last_hs;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      len_q <= '0;
      id_q  <= '0;
    end else if (accept) begin
      len_q <= len_d;
      id_q  <= id_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign row_src    = chan_addr[0];
  assign row_dst    = chan_addr[1];
  assign row_len    = len_q;
  assign done_pulse = done_q;
  assign done_id    = id_q;

  // R7: a stalled row request holds
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (row_valid && !row_ready) |=> (row_valid && $stable(row_src)
                                   && $stable(row_dst) && $stable(row_len)));

  // R8: completion follows a row handshake and lasts one cycle
  a_r8_done_after_hs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_pulse |-> $past(row_valid && row_ready));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_pulse |=> !done_pulse);

  // R2: ready returns together with the completion strobe
  a_r2_ready_on_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_pulse |-> desc_ready);
endmodule

// File: tb/stride_row_expander_test.sv
module stride_row_expander_test;
  typedef struct packed {
    logic [63:0] src;
    logic [63:0] dst;
    logic [31:0] len;
    logic [31:0] sstr;
    logic [31:0] dstr;
    logic [31:0] rows;
    logic [1:0]  cfg;
    logic [31:0] id;
    logic        stall;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [0:NVEC-1] = '{
    // R3: one-dimensional, strides and count ignored
    '{64'h1000, 64'h8000, 32'd64, 32'h100, 32'h200, 32'd5, 2'b00, 32'h11, 1'b0},
    // R4: four rows, independent strides, with stalls
    '{64'h2000, 64'h9000, 32'd32, 32'h40, 32'h80, 32'd4, 2'b10, 32'h22, 1'b1},
    // R5: zero count in two-dimensional mode
    '{64'h3000, 64'hA000, 32'd16, 32'h10, 32'h20, 32'd0, 2'b10, 32'h33, 1'b0},
    // R6: source crosses 2^64
    '{64'hFFFF_FFFF_FFFF_FF00, 64'h100, 32'd8, 32'h80, 32'h8, 32'd3, 2'b10, 32'h44, 1'b1},
    // R9: zero length rows
    '{64'h4000, 64'hB000, 32'd0, 32'h4, 32'h4, 32'd2, 2'b10, 32'h55, 1'b0},
    // R10: bit 0 set with two-dimensional mode
    '{64'h5000, 64'hC000, 32'd12, 32'h30, 32'h60, 32'd2, 2'b11, 32'h66, 1'b1},
    // R10: bit 0 set with one-dimensional mode
    '{64'h6000, 64'hD000, 32'd12, 32'h30, 32'h60, 32'd3, 2'b01, 32'h77, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_valid, desc_ready;
  logic [63:0] desc_src, desc_dst;
  logic [31:0] desc_len, desc_src_stride, desc_dst_stride, desc_rows, desc_id;
  logic [1:0]  desc_cfg;
  logic        row_valid, row_ready;
  logic [63:0] row_src, row_dst;
  logic [31:0] row_len;
  logic        done_pulse;
  logic [31:0] done_id;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stride_row_expander uut (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
    .desc_src_stride(desc_src_stride), .desc_dst_stride(desc_dst_stride),
    .desc_rows(desc_rows), .desc_cfg(desc_cfg), .desc_id(desc_id),
    .row_valid(row_valid), .row_ready(row_ready),
    .row_src(row_src), .row_dst(row_dst), .row_len(row_len),
    .done_pulse(done_pulse), .done_id(done_id)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_desc(input vec_t v);
    desc_src        = v.src;
    desc_dst        = v.dst;
    desc_len        = v.len;
    desc_src_stride = v.sstr;
    desc_dst_stride = v.dstr;
    desc_rows       = v.rows;
    desc_cfg        = v.cfg;
    desc_id         = v.id;
  endtask

  task automatic run_desc(input vec_t v, input bit poke);
    int nrows;
    logic [63:0] es, ed;
    nrows = v.cfg[1] ? ((v.rows == 0) ? 1 : int'(v.rows)) : 1;
    es = v.src;
    ed = v.dst;
    @(negedge clk);
    load_desc(v);
    desc_valid = 1'b1;
    row_ready  = 1'b1;
    chk(desc_ready == 1'b1, "R2 ready idle", 64'(desc_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
    chk(desc_ready == 1'b0, "R2 ready low busy", 64'(desc_ready), 64'd0);
    for (int k = 0; k < nrows; k++) begin
      if (v.stall && (k % 2 == 0)) begin
        row_ready = 1'b0;
        if (poke && k == 0) begin
          desc_valid = 1'b1;
          desc_src = 64'hDEAD_0000; desc_dst = 64'hBEEF_0000;
          desc_len = 32'd999; desc_id = 32'hBAD; desc_rows = 32'd9;
          desc_src_stride = 32'h7; desc_dst_stride = 32'h9; desc_cfg = 2'b10;
        end
        @(negedge clk);
        desc_valid = 1'b0;
        chk(row_valid == 1'b1, "R7 valid held", 64'(row_valid), 64'd1);
        chk(desc_ready == 1'b0, "R2 no busy accept", 64'(desc_ready), 64'd0);
        row_ready = 1'b1;
      end
      chk(row_valid == 1'b1, "R4 row valid", 64'(row_valid), 64'd1);
      chk(row_src == es, "R4/R6 row src", row_src, es);
      chk(row_dst == ed, "R4/R6 row dst", row_dst, ed);
      chk(row_len == v.len, "R3/R9 row len", 64'(row_len), 64'(v.len));
      @(posedge clk);
      @(negedge clk);
      es = es + {32'd0, v.sstr};
      ed = ed + {32'd0, v.dstr};
      if (k < nrows - 1) begin
        chk(done_pulse == 1'b0, "R8 no early done", 64'(done_pulse), 64'd0);
      end
    end
    chk(done_pulse == 1'b1, "R8 done pulse", 64'(done_pulse), 64'd1);
    chk(done_id == v.id, "R8 done id", 64'(done_id), 64'(v.id));
    chk(row_valid == 1'b0, "R4 row count", 64'(row_valid), 64'd0);
    chk(desc_ready == 1'b1, "R2 ready back", 64'(desc_ready), 64'd1);
    @(negedge clk);
    chk(done_pulse == 1'b0, "R8 single cycle", 64'(done_pulse), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    desc_valid = 1'b0;
    row_ready = 1'b0;
    load_desc(VECS[0]);
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(desc_ready == 1'b1, "R1 reset ready", 64'(desc_ready), 64'd1);
    chk(row_valid == 1'b0, "R1 reset valid", 64'(row_valid), 64'd0);
    chk(done_pulse == 1'b0, "R1 reset done", 64'(done_pulse), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_desc(VECS[i], 1'b0);

    // R2: descriptor offered while busy and stalled
    run_desc(VECS[1], 1'b1);

    // R1: reset taken in the middle of a transfer
    @(negedge clk);
    load_desc(VECS[1]);
    desc_valid = 1'b1;
    row_ready  = 1'b0;
    @(negedge clk);
    desc_valid = 1'b0;
    chk(row_valid == 1'b1, "R1 busy before reset", 64'(row_valid), 64'd1);
    rst_n = 1'b0;
    #1;
    chk(row_valid == 1'b0, "R1 mid reset valid", 64'(row_valid), 64'd0);
    chk(desc_ready == 1'b1, "R1 mid reset ready", 64'(desc_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(row_valid == 1'b0, "R1 after release", 64'(row_valid), 64'd0);
    chk(done_pulse == 1'b0, "R1 no stray done", 64'(done_pulse), 64'd0);
    run_desc(VECS[3], 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule